// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Tick Prescaling

This block is a watchdog timer driven by a slow, dedicated oscillator tick that arrives as a one-cycle strobe in the system clock domain. Each tick that the watchdog accepts passes through two prescalers in series. The first divides by a power of eight and the second by a linear ratio. Every output pulse of the second prescaler advances a timeout counter. When that counter has seen a fixed number of prescaled ticks, the block issues a one-cycle reset pulse and sets a sticky status flag.

A configuration word is captured while reset is held and is not read again until the next reset. It holds a hard enable and the two prescaler codes. An erased bit reads as 1 and a programmed bit reads as 0. An erased word therefore gives an always-on watchdog with the longest period. When the hard enable is 0, a software enable input starts and pauses the watchdog. Firmware services the watchdog with a clear strobe, which returns both prescalers and the timeout counter to zero.

Top module: `wdt_cascade`

## Requirements
- R1: While `rst` is high, `wdt_rst_pulse` and `timeout_seen` go low on the next clock edge and all counters return to zero. The configuration word present at that edge is captured.
- R2: Configuration bits [5:4] select the first prescaler ratio. Codes 0, 1, 2 and 3 divide by 1, 8, 64 and 512 respectively.
- R3: Configuration bits [3:0] select the second prescaler ratio. A code value of N divides by N+1, so the ratio ranges from 1 to 16.
- R4: After ratioA × ratioB × TIMEOUT_TICKS accepted ticks with no clear, `wdt_rst_pulse` is high for exactly the one cycle that follows the clock edge of the final tick.
- R5: When configuration bit [6] (hard enable) is 1, every tick is accepted whatever the level of `sw_en`.
- R6: When the hard enable is 0, ticks are accepted only while `sw_en` is 1. While `sw_en` is 0, all counts hold their values and no pulse is produced.
- R7: A `kick` cycle clears both prescalers and the timeout counter. A tick in that same cycle is discarded, and no pulse follows a `kick` cycle.
- R8: `timeout_seen` rises together with the first timeout pulse. It stays high until `rst` is asserted.
- R9: Changes to `cfg_word` while `rst` is low have no effect on timing or enable.
- R10: After each timeout all counts start again from zero, so the pulses repeat with the same period while no clear arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also captures the configuration |
| osc_tick | input | 1 | One-cycle strobe from the slow watchdog oscillator |
| cfg_word | input | 7 | [6] hard enable, [5:4] first prescaler code, [3:0] second prescaler code |
| sw_en | input | 1 | Software enable, used only when the hard enable is 0 |
| kick | input | 1 | Clear strobe that restarts the whole count |
| wdt_rst_pulse | output | 1 | One-cycle timeout reset request (registered) |
| timeout_seen | output | 1 | Sticky flag: a timeout has occurred since reset (registered) |

## Verification
The bench builds the block with TIMEOUT_TICKS = 4 rather than the default of 16. This shortens every period by a factor of four. As a result, all sixteen second-stage codes, all four first-stage codes, and the fully erased configuration word can each reach at least one timeout inside the run. The erased word gives the largest period, 512 × 16 × 4 = 32768 ticks. With the shorter periods, random tick densities, random `sw_en` toggling and random clear strobes still produce many timeouts and wrap-arounds. The bench also exercises clears that land on the same cycle as the final tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int A_CODE_W   = 2;
  localparam int B_CODE_W   = 4;
  localparam int A_LOG_STEP = 3;
  localparam int A_CNT_W    = A_LOG_STEP * ((1 << A_CODE_W) - 1);
  localparam int CFG_W      = 1 + A_CODE_W + B_CODE_W;

  typedef struct packed {
    logic                hard_en;
    logic [A_CODE_W-1:0] a_code;
    logic [B_CODE_W-1:0] b_code;
  } wdt_cfg_t;

  // terminal count of the first stage: 8^code - 1
  function automatic logic [A_CNT_W-1:0] a_div_m1(input logic [A_CODE_W-1:0] code);
    logic [A_CNT_W:0] p;
    p = {{A_CNT_W{1'b0}}, 1'b1} << (A_LOG_STEP * code);
    p = p - {{A_CNT_W{1'b0}}, 1'b1};
    return p[A_CNT_W-1:0];
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step_in,
  input  logic [W-1:0] ratio_m1,
  output logic         carry
);
  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end = (cnt >= ratio_m1);
  assign carry  = step_in & at_end;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step_in) begin
      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step_in,
  output logic expire
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  assign expire  = step_in & at_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step_in) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_cascade.sv
module wdt_cascade
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             sw_en,
  input  logic             kick,
  output logic             wdt_rst_pulse,
  output logic             timeout_seen
);
  wdt_cfg_t           cfg_q;
  logic               hard_en_q;
  logic               run;
  logic               step;
  logic [A_CNT_W-1:0] a_m1;
  logic               a_carry;
  logic               b_carry;
  logic               expire;

  // configuration is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= wdt_cfg_t'(cfg_word);
  end

  assign hard_en_q = cfg_q.hard_en;
  assign run       = hard_en_q | sw_en;
  assign step      = osc_tick & run & ~kick;
  assign a_m1      = a_div_m1(cfg_q.a_code);

  wdt_prescaler #(.W(A_CNT_W)) u_pre_a (
    .clk      (clk),
    .rst      (rst),
    .clr      (kick),
    .step_in  (step),
    .ratio_m1 (a_m1),
    .carry    (a_carry)
  );

  wdt_prescaler #(.W(B_CODE_W)) u_pre_b (
    .clk      (clk),
    .rst      (rst),
    .clr      (kick),
    .step_in  (a_carry),
    .ratio_m1 (cfg_q.b_code),
    .carry    (b_carry)
  );

  wdt_timeout_ctr #(.TICKS(TIMEOUT_TICKS)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .clr     (kick),
    .step_in (b_carry),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_rst_pulse <= 1'b0;
      timeout_seen  <= 1'b0;
    end else begin
      wdt_rst_pulse <= expire;
      if (expire) timeout_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_cascade_chk.sv
module wdt_cascade_chk #(
  parameter int TIMEOUT_TICKS = 16
) (
  input logic clk,
  input logic rst,
  input logic sw_en,
  input logic kick,
  input logic hard_en_q,
  input logic wdt_rst_pulse,
  input logic timeout_seen
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!wdt_rst_pulse && !timeout_seen));

  p_pulse_flags_r8: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_pulse |-> timeout_seen);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    timeout_seen |=> timeout_seen);

  p_kick_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    kick |=> !wdt_rst_pulse);

  p_paused_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!hard_en_q && !sw_en) |=> !wdt_rst_pulse);

  p_cfg_held_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(hard_en_q));

  generate
    if (TIMEOUT_TICKS > 1) begin : g_single
      p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_pulse |=> !wdt_rst_pulse);
    end
  endgenerate
endmodule

bind wdt_cascade wdt_cascade_chk #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .sw_en         (sw_en),
  .kick          (kick),
  .hard_en_q     (hard_en_q),
  .wdt_rst_pulse (wdt_rst_pulse),
  .timeout_seen  (timeout_seen)
);

// File: tb/wdt_cascade_test.sv
module wdt_cascade_test;
  localparam int T = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic [6:0] cfg_word = 7'h7F;
  logic       sw_en = 1'b0;
  logic       kick = 1'b0;
  logic       wdt_rst_pulse;
  logic       timeout_seen;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // bench model state
  int   m_cnt = 0;
  int   m_period = 1;
  bit   m_hard = 1'b1;
  bit   m_pulse = 1'b0;
  bit   m_flag = 1'b0;
  int   m_fires = 0;

  always #2.5 clk = ~clk;

  wdt_cascade #(.TIMEOUT_TICKS(T)) uut (
    .clk           (clk),
    .rst           (rst),
    .osc_tick      (osc_tick),
    .cfg_word      (cfg_word),
    .sw_en         (sw_en),
    .kick          (kick),
    .wdt_rst_pulse (wdt_rst_pulse),
    .timeout_seen  (timeout_seen)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period_of(input logic [6:0] w);
    int ra;
    int rb;
    ra = 1 << (3 * int'(w[5:4]));
    rb = int'(w[3:0]) + 1;
    return ra * rb * T;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (wdt_rst_pulse !== m_pulse || timeout_seen !== m_flag) begin
      errors++;
      $display("FAIL %s cycle %0d: pulse=%b flag=%b expected pulse=%b flag=%b",
               tag, cyc, wdt_rst_pulse, timeout_seen, m_pulse, m_flag);
    end
  endtask

  task automatic do_reset(input logic [6:0] w, input string tag);
    @(negedge clk);
    rst = 1'b1;
    cfg_word = w;
    osc_tick = 1'b1;
    kick = 1'b0;
    @(posedge clk);
    @(negedge clk);
    m_cnt = 0; m_pulse = 0; m_flag = 0;
    m_period = period_of(w);
    m_hard = w[6];
    check(tag);
    rst = 1'b0;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit t, input bit s, input bit k, input bit scramble,
                      input string tag);
    osc_tick = t; sw_en = s; kick = k;
    if (scramble) cfg_word = 7'($urandom);
    @(posedge clk);
    m_pulse = 1'b0;
    if (k) m_cnt = 0;
    else if (t && (m_hard || s)) begin
      m_cnt++;
      if (m_cnt == m_period) begin
        m_cnt = 0; m_pulse = 1'b1; m_flag = 1'b1; m_fires++;
      end
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic run(input int n, input int tick_pct, input int sw_mode,
                     input int kick_pct, input bit scramble, input string tag);
    for (int i = 0; i < n; i++) begin
      bit t;
      bit s;
      bit k;
      t = ($urandom % 100) < tick_pct;
      s = (sw_mode == 2) ? 1'($urandom) : 1'(sw_mode);
      k = ($urandom % 1000) < kick_pct;
      step(t, s, k, scramble, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);

    // R1: reset state; R4/R10/R5: shortest period, hard on, sw off
    do_reset(7'b1_00_0000, "R1");
    run(30, 100, 0, 0, 1'b0, "R4 R10 R5");

    // R9: cfg scrambled after reset with hard off and sw off -> nothing
    do_reset(7'b0_00_0000, "R1");
    run(200, 100, 0, 0, 1'b1, "R9");

    // R3: every second-stage code, first stage /1
    for (int b = 0; b < 16; b++) begin
      do_reset({1'b1, 2'b00, 4'(b)}, "R1");
      run(3 * (b + 1) * T + 5, 100, 0, 0, 1'b0, "R3");
      run(60, 60, 0, 0, 1'b0, "R3");
    end

    // R2: every first-stage code
    for (int a = 0; a < 4; a++) begin
      int bb;
      bb = (a == 3) ? 0 : int'($urandom % 3);
      do_reset({1'b1, 2'(a), 4'(bb)}, "R1");
      run(2 * period_of({1'b1, 2'(a), 4'(bb)}) + 5, 100, 0, 0, 1'b0, "R2");
    end

    // R6: hard off, sw random and pauses
    do_reset(7'b0_01_0001, "R1");
    run(3000, 70, 2, 0, 1'b1, "R6");
    run(50, 100, 0, 0, 1'b0, "R6");

    // R5: hard on, sw random has no effect
    do_reset(7'b1_01_0000, "R1");
    run(2000, 80, 2, 0, 1'b0, "R5");

    // R7: clear strobes, including a clear on the final tick
    do_reset(7'b1_00_0001, "R1");
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
    run(3000, 90, 2, 60, 1'b1, "R7");

    // R8: flag sticky then cleared by reset
    run(100, 0, 0, 0, 1'b0, "R8");
    do_reset(7'b1_00_0000, "R8");

    // R2 R4: fully erased word, longest period
    do_reset(7'h7F, "R1");
    m_fires = 0;
    run(period_of(7'h7F) + 10, 100, 0, 0, 1'b1, "R4");
    checks++;
    if (m_fires != 1) begin
      errors++;
      $display("FAIL R4 erased-word timeouts: got %0d expected 1", m_fires);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, cycle %0d expected below 190000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule